// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Device Model

This block is a synthesizable model of the memory device that sits on a three-wire serial bus. The bus has a chip select, a serial clock and a data line in each direction. While chip select is high, the model samples the serial input on each rising edge of the serial clock. It first waits for a start bit, then takes a two-bit opcode and an address. After that it carries out a read, a write, or one of three special commands: set the write-enable latch, clear it, or erase the whole array. The storage is parameterised to 128, 256 or 512 bytes and is organised either as bytes or as 16-bit words. The address width follows from that choice.

Reads shift the addressed word out MSB first. By default the read keeps going into the following words for as long as the serial clock runs. A single-word variant stops after one word. Writes and erase-all are accepted only while the enable latch is set. Each of them holds the device busy for a parameterised programming interval. The serial output reports that state whenever the device is selected and idle. Two further options lengthen frames:
- one adds a clock between the read address and the first data bit;
- the other adds two bits to the end of the special commands.

The serial pins follow a bit-serial wire protocol and have no valid/ready handshake. The only back-pressure is the ready level on the serial output. The host must poll it, and any instruction sent while the device is busy is discarded. The serial clock is sampled in the system clock domain, so each of its high and low phases must last at least one system clock.

Top module: `mw_eeprom`

## Requirements
- R1: While chip select is high, zeros before the start bit (a 1) are ignored. The start bit is followed by a two-bit opcode, MSB first: 10 is read, 01 is write, 00 is special. The address follows MSB first and is log2(SIZE_BYTES) bits wide in byte organisation, or one bit fewer in 16-bit organisation. All bits are sampled on rising serial-clock edges.
- R2: After the last address bit of a read, the serial output presents the MSB of the addressed word. Each further rising serial-clock edge advances it by one bit towards the LSB.
- R3: Without the single-word option, a read continues into the next address after the LSB, wrapping from the top address to 0. With the single-word option, the output is 0 after the word's last bit and further clocks are ignored.
- R4: A write takes 8 data bits (byte organisation) or 16 data bits (16-bit organisation), MSB first, and stores them at the given address.
- R5: A special command is chosen by the top two address bits. 11 sets the write-enable latch and 00 clears it. 10 sets every bit of the array to 1.
- R6: The write-enable latch is clear after reset. Write and erase-all have no effect and start no programming while the latch is clear.
- R7: An accepted write or erase-all makes the device busy for max(PROG_CYCLES, words+1) system clocks. While busy, a selected idle device drives the serial output to 0, and it drives 1 once the interval has ended. Start bits received while busy are ignored.
- R8: With chip select low the serial output is 0. Dropping chip select part-way through a frame abandons it, and the decoder waits for a new start bit.
- R9: With EXTRA_READ set, a read needs one extra rising edge after the address before the MSB is presented.
- R10: With LONG_INSTR set, a special command takes effect only after two further rising edges following its address. If chip select drops before them, the command is discarded.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cs | input | 1 | Chip select, active high |
| sk | input | 1 | Serial clock from the host, sampled by clk |
| di | input | 1 | Serial data from the host |
| so | output | 1 | Serial data or ready status to the host |

## Verification
The assertions assume that chip select, serial clock and serial input are synchronous to the system clock. They also assume that each serial-clock phase spans at least one system clock, so that each host edge yields exactly one sampled rising edge. The bench keeps to this by changing these pins only on falling system-clock edges and holding every serial-clock phase for several system clocks. It also changes the serial input only while the serial clock is low. Frames sent while the device is busy are kept shorter than the programming interval, so that none of their 1 bits can be taken as a start bit once the device becomes ready.

// File: rtl/mw_eeprom_pkg.sv
package mw_eeprom_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_OPC, ST_ADDR, ST_PAD, ST_WDATA, ST_RDATA, ST_DONE
  } mw_state_t;

  localparam logic [1:0] OPC_READ    = 2'b10;
  localparam logic [1:0] OPC_WRITE   = 2'b01;
  localparam logic [1:0] OPC_SPECIAL = 2'b00;

  localparam logic [1:0] SP_ENABLE  = 2'b11;
  localparam logic [1:0] SP_DISABLE = 2'b00;
  localparam logic [1:0] SP_ERASE   = 2'b10;
endpackage

// File: rtl/mw_sk_edge.sv
module mw_sk_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic sk,
  output logic sk_rise
);
  logic sk_q;

  always_ff @(posedge clk) begin
    if (!rst_n) sk_q <= 1'b0;
    else        sk_q <= sk;
  end

  assign sk_rise = sk & ~sk_q;
endmodule

// File: rtl/mw_decoder.sv
module mw_decoder
  import mw_eeprom_pkg::*;
#(
  parameter int AW          = 7,
  parameter int DW          = 8,
  parameter int SINGLE_WORD = 0,
  parameter int EXTRA_READ  = 0,
  parameter int LONG_INSTR  = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs,
  input  logic          sk_rise,
  input  logic          di,
  input  logic          busy,
  input  logic [DW-1:0] rd_data,
  output logic [AW-1:0] rd_addr,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic          erase_go,
  output logic          wel,
  output logic          idle,
  output logic          so
);
  localparam int MAXW = (AW > DW) ? AW : DW;
  localparam int CW   = $clog2(MAXW);
  localparam int BW   = $clog2(DW);

  mw_state_t     state;
  logic [1:0]    opc;
  logic [AW-1:0] addr;
  logic [DW-1:0] sr;
  logic [CW-1:0] cnt;
  logic [BW-1:0] bidx;
  logic [AW-1:0] a_next;
  logic [1:0]    sp_cmd;
  logic          sp_now;

  assign a_next = {addr[AW-2:0], di};
  assign sp_cmd = (state == ST_ADDR) ? a_next[AW-1 -: 2] : addr[AW-1 -: 2];

  always_comb begin
    sp_now = 1'b0;
    if (cs && sk_rise && opc == OPC_SPECIAL) begin
      if (state == ST_ADDR && cnt == CW'(AW-1) && LONG_INSTR == 0) sp_now = 1'b1;
      if (state == ST_PAD && cnt == CW'(1)) sp_now = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= ST_IDLE;
      opc      <= '0;
      addr     <= '0;
      sr       <= '0;
      cnt      <= '0;
      bidx     <= '0;
      wel      <= 1'b0;
      wr_en    <= 1'b0;
      erase_go <= 1'b0;
    end else begin
      wr_en    <= 1'b0;
      erase_go <= 1'b0;
      if (!cs) begin
        state <= ST_IDLE;
      end else if (sk_rise) begin
        case (state)
          ST_IDLE: if (di && !busy) begin
            state <= ST_OPC;
            cnt   <= '0;
          end
          ST_OPC: begin
            opc <= {opc[0], di};
            if (cnt == CW'(1)) begin
              state <= ST_ADDR;
              cnt   <= '0;
            end else cnt <= cnt + CW'(1);
          end
          ST_ADDR: begin
            addr <= a_next;
            if (cnt == CW'(AW-1)) begin
              cnt  <= '0;
              bidx <= '0;
              case (opc)
                OPC_READ:    state <= (EXTRA_READ != 0) ? ST_PAD : ST_RDATA;
                OPC_WRITE:   state <= ST_WDATA;
                OPC_SPECIAL: state <= (LONG_INSTR != 0) ? ST_PAD : ST_DONE;
                default:     state <= ST_DONE;
              endcase
            end else cnt <= cnt + CW'(1);
          end
          ST_PAD: begin
            if (opc == OPC_READ)       state <= ST_RDATA;
            else if (cnt == CW'(1))    state <= ST_DONE;
            else                       cnt   <= cnt + CW'(1);
          end
          ST_WDATA: begin
            sr <= {sr[DW-2:0], di};
            if (cnt == CW'(DW-1)) begin
              wr_en <= wel;
              state <= ST_DONE;
            end else cnt <= cnt + CW'(1);
          end
          ST_RDATA: begin
            if (bidx == BW'(DW-1)) begin
              bidx <= '0;
              if (SINGLE_WORD != 0) state <= ST_DONE;
              else                  addr  <= addr + AW'(1);
            end else bidx <= bidx + BW'(1);
          end
          default: ;
        endcase
      end
      if (sp_now) begin
        case (sp_cmd)
          SP_ENABLE:  wel      <= 1'b1;
          SP_DISABLE: wel      <= 1'b0;
          SP_ERASE:   erase_go <= wel;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    if (!cs)                    so = 1'b0;
    else if (state == ST_RDATA) so = rd_data[BW'(DW-1) - bidx];
    else if (state == ST_IDLE)  so = ~busy;
    else                        so = 1'b0;
  end

  assign idle    = (state == ST_IDLE);
  assign rd_addr = addr;
  assign wr_addr = addr;
  assign wr_data = sr;
endmodule

// File: rtl/mw_store.sv
module mw_store #(
  parameter int AW          = 7,
  parameter int DW          = 8,
  parameter int PROG_CYCLES = 6000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          erase_go,
  output logic          busy
);
  localparam int DEPTH    = 1 << AW;
  localparam int BUSY_LEN = (PROG_CYCLES > DEPTH) ? PROG_CYCLES : DEPTH + 1;
  localparam int TW       = $clog2(BUSY_LEN + 1);

  logic [DW-1:0] mem [DEPTH];
  logic [TW-1:0] timer;
  logic          sweep_on;
  logic [AW-1:0] sweep_idx;

  always_ff @(posedge clk) begin
    if (wr_en)         mem[wr_addr]   <= wr_data;
    else if (sweep_on) mem[sweep_idx] <= '1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      timer     <= '0;
      sweep_on  <= 1'b0;
      sweep_idx <= '0;
    end else begin
      if (wr_en || erase_go) timer <= TW'(BUSY_LEN);
      else if (timer != '0)  timer <= timer - TW'(1);
      if (erase_go) begin
        sweep_on  <= 1'b1;
        sweep_idx <= '0;
      end else if (sweep_on) begin
        sweep_idx <= sweep_idx + AW'(1);
        if (sweep_idx == AW'(DEPTH-1)) sweep_on <= 1'b0;
      end
    end
  end

  assign rd_data = mem[rd_addr];
  assign busy    = (timer != '0);
endmodule

// File: rtl/mw_eeprom.sv
module mw_eeprom #(
  parameter int SIZE_BYTES  = 128,
  parameter int WORD16      = 0,
  parameter int SINGLE_WORD = 0,
  parameter int EXTRA_READ  = 0,
  parameter int LONG_INSTR  = 0,
  parameter int PROG_CYCLES = 6000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs,
  input  logic sk,
  input  logic di,
  output logic so
);
  localparam int AW = $clog2(SIZE_BYTES) - ((WORD16 != 0) ? 1 : 0);
  localparam int DW = (WORD16 != 0) ? 16 : 8;

  logic          sk_rise;
  logic          busy;
  logic          wr_en;
  logic          erase_go;
  logic          wel;
  logic          idle;
  logic [AW-1:0] rd_addr;
  logic [AW-1:0] wr_addr;
  logic [DW-1:0] rd_data;
  logic [DW-1:0] wr_data;

  mw_sk_edge u_edge (
    .clk(clk), .rst_n(rst_n), .sk(sk), .sk_rise(sk_rise)
  );

  mw_decoder #(
    .AW(AW), .DW(DW), .SINGLE_WORD(SINGLE_WORD),
    .EXTRA_READ(EXTRA_READ), .LONG_INSTR(LONG_INSTR)
  ) u_dec (
    .clk(clk), .rst_n(rst_n), .cs(cs), .sk_rise(sk_rise), .di(di),
    .busy(busy), .rd_data(rd_data), .rd_addr(rd_addr), .wr_en(wr_en),
    .wr_addr(wr_addr), .wr_data(wr_data), .erase_go(erase_go),
    .wel(wel), .idle(idle), .so(so)
  );

  mw_store #(.AW(AW), .DW(DW), .PROG_CYCLES(PROG_CYCLES)) u_store (
    .clk(clk), .rst_n(rst_n), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .erase_go(erase_go), .busy(busy)
  );
endmodule

// File: rtl/mw_eeprom_chk.sv
module mw_eeprom_chk (
  input logic clk,
  input logic rst_n,
  input logic cs,
  input logic sk_rise,
  input logic busy,
  input logic wr_en,
  input logic erase_go,
  input logic wel,
  input logic idle
);
  // R6
  write_needs_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> wel);

  // R6
  erase_needs_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    erase_go |-> wel);

  // R7
  busy_has_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(wr_en || erase_go));

  // R7
  busy_blocks_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cs && idle && sk_rise) |=> idle);

  // R7
  no_write_while_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !wr_en);

  // R8
  deselect_aborts_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cs |=> idle);
endmodule

bind mw_eeprom mw_eeprom_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cs(cs), .sk_rise(sk_rise), .busy(busy),
  .wr_en(wr_en), .erase_go(erase_go), .wel(wel), .idle(idle)
);

// File: tb/mw_eeprom_test.sv
module mw_eeprom_test;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] cs = '0;
  logic [1:0] sk = '0;
  logic [1:0] di = '0;
  wire  [1:0] so;
  int         n_chk = 0;
  int         n_fail = 0;
  bit         done = 1'b0;
  bit         wel_m [2];
  logic [15:0] m0 [128];
  logic [15:0] m1 [128];

  always #(CLK_PERIOD/2) clk = ~clk;

  mw_eeprom #(.SIZE_BYTES(128), .PROG_CYCLES(200)) uut (
    .clk(clk), .rst_n(rst_n), .cs(cs[0]), .sk(sk[0]), .di(di[0]), .so(so[0])
  );

  mw_eeprom #(.SIZE_BYTES(256), .WORD16(1), .SINGLE_WORD(1), .EXTRA_READ(1),
              .LONG_INSTR(1), .PROG_CYCLES(200)) uut_q (
    .clk(clk), .rst_n(rst_n), .cs(cs[1]), .sk(sk[1]), .di(di[1]), .so(so[1])
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick(input int d, input bit b);
    di[d] = b;
    repeat (2) @(negedge clk);
    sk[d] = 1'b1;
    repeat (3) @(negedge clk);
    sk[d] = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic frame(input int d, input bit [1:0] op, input bit [6:0] a);
    cs[d] = 1'b1;
    repeat (2) @(negedge clk);
    tick(d, 1'b1);
    tick(d, op[1]);
    tick(d, op[0]);
    for (int i = 6; i >= 0; i--) tick(d, a[i]);
  endtask

  task automatic release_cs(input int d);
    cs[d] = 1'b0;
    di[d] = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  task automatic special(input int d, input bit [1:0] code, input bit pad);
    frame(d, 2'b00, {code, 5'b0});
    if (pad) begin
      tick(d, 1'b0);
      tick(d, 1'b0);
    end
    release_cs(d);
    if (pad || d == 0) begin
      if (code == 2'b11) wel_m[d] = 1'b1;
      if (code == 2'b00) wel_m[d] = 1'b0;
    end
  endtask

  task automatic wait_ready(input int d, input string tag, input bit exp_busy);
    cs[d] = 1'b1;
    repeat (2) @(negedge clk);
    check(tag, {15'b0, so[d]}, exp_busy ? 16'h0 : 16'h1);
    if (exp_busy) begin
      for (int i = 0; i < 1000 && !so[d]; i++) @(negedge clk);
      check(tag, {15'b0, so[d]}, 16'h1);
    end
    release_cs(d);
  endtask

  task automatic write_word(input int d, input int a, input logic [15:0] v);
    frame(d, 2'b01, 7'(a));
    for (int i = (d != 0 ? 15 : 7); i >= 0; i--) tick(d, v[i]);
    release_cs(d);
    if (wel_m[d]) begin
      if (d == 0) m0[a] = {8'h00, v[7:0]};
      else        m1[a] = v;
    end
  endtask

  task automatic read_check(input int d, input int a, input int n, input string tag);
    logic [15:0] v;
    logic [15:0] e;
    frame(d, 2'b10, 7'(a));
    if (d == 1) tick(d, 1'b0);
    for (int w = 0; w < n; w++) begin
      v = '0;
      for (int b = 0; b < (d != 0 ? 16 : 8); b++) begin
        v = {v[14:0], so[d]};
        tick(d, 1'b0);
      end
      e = (d != 0) ? m1[(a + w) % 128] : m0[(a + w) % 128];
      check(tag, v, e);
    end
    // R3: single-word device goes quiet after its word
    if (d == 1) check("R3", {15'b0, so[d]}, 16'h0);
    release_cs(d);
  endtask

  initial begin
    int a;
    logic [15:0] v;
    wel_m[0] = 1'b0;
    wel_m[1] = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // R8: quiet output while deselected after reset
    check("R8", {15'b0, so[0]}, 16'h0);
    check("R8", {15'b0, so[1]}, 16'h0);
    // R7: selected and idle with nothing pending reads as ready
    wait_ready(0, "R7", 1'b0);

    // R6: latch clear after reset, so the write starts no programming
    write_word(0, 5, 16'h003C);
    wait_ready(0, "R6", 1'b0);

    // R5: enable, erase everything, then read back all ones
    special(0, 2'b11, 1'b0);
    special(0, 2'b10, 1'b0);
    wait_ready(0, "R5", 1'b1);
    for (int i = 0; i < 128; i++) m0[i] = 16'h00FF;
    read_check(0, 5, 2, "R5");
    read_check(0, 126, 2, "R5");

    // R5 / R6: disable, then a write is ignored
    special(0, 2'b00, 1'b0);
    write_word(0, 9, 16'h0012);
    wait_ready(0, "R6", 1'b0);
    read_check(0, 9, 1, "R6");

    special(0, 2'b11, 1'b0);
    void'($urandom(32'h5EED));
    for (int k = 0; k < 12; k++) begin
      a = $urandom % 128;
      v = 16'($urandom % 256);
      write_word(0, a, v);
      wait_ready(0, "R7", 1'b1);
      read_check(0, a, 1, "R4");
      read_check(0, $urandom % 128, 1, "R2");
    end
    for (int k = 0; k < 4; k++) read_check(0, $urandom % 128, 4, "R3");

    // R3: sequential read wraps from top address to 0
    write_word(0, 127, 16'h00A5);
    wait_ready(0, "R4", 1'b1);
    write_word(0, 0, 16'h005A);
    wait_ready(0, "R4", 1'b1);
    read_check(0, 127, 2, "R3");

    // R1: leading zeros before the start bit are ignored
    cs[0] = 1'b1;
    tick(0, 1'b0);
    tick(0, 1'b0);
    read_check(0, 0, 1, "R1");

    // R7: a frame sent while busy is discarded
    write_word(0, 20, 16'h0077);
    v = m0[21];
    frame(0, 2'b01, 7'd21);
    for (int i = 7; i >= 0; i--) tick(0, 1'b1);
    release_cs(0);
    wait_ready(0, "R7", 1'b1);
    read_check(0, 21, 1, "R7");
    check("R7", m0[21], v);

    // R8: deselect mid-frame abandons it
    cs[0] = 1'b1;
    repeat (2) @(negedge clk);
    tick(0, 1'b1);
    tick(0, 1'b0);
    tick(0, 1'b1);
    tick(0, 1'b1);
    release_cs(0);
    check("R8", {15'b0, so[0]}, 16'h0);
    read_check(0, 20, 1, "R8");

    // R10: long special commands need two trailing bits
    special(1, 2'b11, 1'b1);
    write_word(1, 3, 16'hBEEF);
    wait_ready(1, "R10", 1'b1);
    // R9: extra clock before read data
    read_check(1, 3, 1, "R9");
    special(1, 2'b00, 1'b0);
    write_word(1, 4, 16'hCAFE);
    wait_ready(1, "R10", 1'b1);
    read_check(1, 4, 1, "R4");
    special(1, 2'b00, 1'b1);
    write_word(1, 5, 16'h0F0F);
    wait_ready(1, "R6", 1'b0);
    special(1, 2'b11, 1'b1);
    for (int k = 0; k < 6; k++) begin
      a = $urandom % 128;
      v = 16'($urandom);
      write_word(1, a, v);
      wait_ready(1, "R4", 1'b1);
      read_check(1, a, 1, "R9");
    end

    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end
endmodule